// File: doc/BRIEF.md
# Multipath Complex Channel Filter

This block applies a time-varying multipath channel to a stream of complex baseband samples. One sample pair (in-phase and quadrature) enters per clock while the block runs. Each part has its own delay line of eight registers, with one sample period between taps. Each of twelve propagation paths picks one tap through a small configuration register. It multiplies the delayed complex sample by that path's complex coefficient, and a new coefficient can be presented on every clock. All path products are summed at full precision. The sum is rounded and saturated back to the sample width, and the result appears after a fixed pipeline delay.

Path delays are integers in units of the sample period. Two paths whose physical delays differ by less than one period are given the same tap, and their products simply add. The tap registers are written through a simple write strobe, but only while the block is idle (`enable` low). While `enable` is low the delay lines hold their contents, and once the pipeline drains the output reads zero. The pipeline depth does not depend on the tap configuration, so every channel setting has the same input-to-output latency.

Top module: `chanTapFilter`

## Requirements
- R1: After reset the outputs `outI` and `outQ` are zero, `outValid` is low, every path tap is 0 and both delay lines hold zeros.
- R2: A sample pair (xI, xQ) captured on clock edge n with `enable` high affects the output register on edge n+3. The output for that sample is the sum over paths of the product (xI·hI − xQ·hQ) + j(xI·hQ + xQ·hI), where x is the sample held k periods earlier and k is the path's tap. Coefficient h for path p is the signed 16-bit slice `coefI/coefQ[16p+15:16p]`.
- R3: Paths configured to the same tap each contribute their own product, and those products add at that tap.
- R4: Tap values 0 to 7 are all usable; tap 7 delays by seven sample periods.
- R5: The coefficients applied to the sample captured on edge n are the ones present on the ports at edge n+1, so they can change every clock.
- R6: Coefficients are signed with 15 fraction bits. The full-precision sum S is scaled to floor((S + 2^14) / 2^15), which rounds halves upward.
- R7: A scaled result above 32767 is output as 32767, and one below −32768 is output as −32768.
- R8: While `enable` is low, a clock with `cfgWrEn` high loads `cfgTap` into the tap register of path `cfgPath`, for path numbers 0 to 11.
- R9: Configuration writes made while `enable` is high are ignored, and the tap registers keep their values.
- R10: `outValid` is high exactly on the output of a sample captured with `enable` high. When `outValid` is low, `outI` and `outQ` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run: capture a sample and shift the delay lines |
| inI | input | 16 | In-phase input sample, signed |
| inQ | input | 16 | Quadrature input sample, signed |
| coefI | input | 192 | Real parts of the twelve path coefficients, 16 bits each |
| coefQ | input | 192 | Imaginary parts of the twelve path coefficients, 16 bits each |
| cfgWrEn | input | 1 | Tap register write strobe (honoured only when idle) |
| cfgPath | input | 4 | Path number to write |
| cfgTap | input | 3 | Tap index to write |
| outI | output | 16 | In-phase output, signed |
| outQ | output | 16 | Quadrature output, signed |
| outValid | output | 1 | Output corresponds to a captured sample |

## Verification
The assertions assume that `rstN` is held long enough for the valid pipeline to clear, and that `enable` is low during reset. The bench drives `enable` low throughout reset and for several cycles afterwards. The configuration properties also assume `cfgPath` and `cfgTap` are stable for the whole clock period around a write strobe. The bench changes every input only on the falling clock edge, so each strobe lasts exactly one full period.

// File: rtl/chanPkg.sv
package chanPkg;
  // Number of clock edges from sample capture to output register update.
  localparam int LATENCY = 3;

  typedef struct packed {
    logic shift;    // advance both delay lines by one sample
    logic outLoad;  // sum register holds a valid sample
  } ctlStrobe_t;
endpackage

// File: rtl/chanPathMul.sv
module chanPathMul #(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  localparam int MUL_W = DATA_W + COEF_W,
  localparam int PROD_W = MUL_W + 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic signed [DATA_W-1:0] xI,
  input  logic signed [DATA_W-1:0] xQ,
  input  logic signed [COEF_W-1:0] hI,
  input  logic signed [COEF_W-1:0] hQ,
  output logic signed [PROD_W-1:0] pI,
  output logic signed [PROD_W-1:0] pQ
);
  logic signed [MUL_W-1:0] mII, mQQ, mIQ, mQI;

  always_comb begin
    mII = xI * hI;
    mQQ = xQ * hQ;
    mIQ = xI * hQ;
    mQI = xQ * hI;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pI <= '0;
      pQ <= '0;
    end else begin
      pI <= {mII[MUL_W-1], mII} - {mQQ[MUL_W-1], mQQ};
      pQ <= {mIQ[MUL_W-1], mIQ} + {mQI[MUL_W-1], mQI};
    end
  end
endmodule

// File: rtl/chanCtl.sv
module chanCtl
  import chanPkg::*;
#(
  parameter int NUM_PATHS = 12,
  parameter int DEPTH = 8,
  localparam int TAP_W = $clog2(DEPTH),
  localparam int PATH_W = $clog2(NUM_PATHS)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       enable,
  input  logic                       cfgWrEn,
  input  logic [PATH_W-1:0]          cfgPath,
  input  logic [TAP_W-1:0]           cfgTap,
  output logic [NUM_PATHS*TAP_W-1:0] tapFlat,
  output ctlStrobe_t                 strobe,
  output logic                       outValid
);
  logic [TAP_W-1:0] tapReg [NUM_PATHS];
  logic [LATENCY-1:0] validPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int p = 0; p < NUM_PATHS; p++) tapReg[p] <= '0;
    end else if (cfgWrEn && !enable) begin
      for (int p = 0; p < NUM_PATHS; p++)
        if (int'(cfgPath) == p) tapReg[p] <= cfgTap;
    end
  end

  generate
    for (genvar g = 0; g < NUM_PATHS; g++) begin : gFlat
      assign tapFlat[g*TAP_W +: TAP_W] = tapReg[g];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validPipe <= '0;
      outValid  <= 1'b0;
    end else begin
      validPipe <= {validPipe[LATENCY-2:0], enable};
      outValid  <= validPipe[LATENCY-1];
    end
  end

  always_comb begin
    strobe.shift   = enable;
    strobe.outLoad = validPipe[LATENCY-1];
  end
endmodule

// File: rtl/chanDatapath.sv
module chanDatapath
  import chanPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter int NUM_PATHS = 12,
  parameter int DEPTH = 8,
  localparam int TAP_W = $clog2(DEPTH),
  localparam int PROD_W = DATA_W + COEF_W + 1,
  localparam int SUM_W = PROD_W + $clog2(NUM_PATHS),
  localparam int FRAC = COEF_W - 1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  ctlStrobe_t                  strobe,
  input  logic [NUM_PATHS*TAP_W-1:0]  tapFlat,
  input  logic signed [DATA_W-1:0]    inI,
  input  logic signed [DATA_W-1:0]    inQ,
  input  logic [NUM_PATHS*COEF_W-1:0] coefI,
  input  logic [NUM_PATHS*COEF_W-1:0] coefQ,
  output logic signed [DATA_W-1:0]    outI,
  output logic signed [DATA_W-1:0]    outQ
);
  localparam logic signed [SUM_W-1:0] HALF = SUM_W'(1) <<< (FRAC - 1);
  localparam logic signed [SUM_W-1:0] MAX_V = SUM_W'((1 <<< (DATA_W - 1)) - 1);
  localparam logic signed [SUM_W-1:0] MIN_V = -(SUM_W'(1) <<< (DATA_W - 1));

  logic signed [DATA_W-1:0] lineI [DEPTH];
  logic signed [DATA_W-1:0] lineQ [DEPTH];
  logic signed [PROD_W-1:0] prodI [NUM_PATHS];
  logic signed [PROD_W-1:0] prodQ [NUM_PATHS];
  logic signed [SUM_W-1:0]  sumI, sumQ, accI, accQ;
  logic signed [SUM_W-1:0]  scaledI, scaledQ;
  logic signed [DATA_W-1:0] satI, satQ;

  // Separate delay lines for the two parts; hold while idle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < DEPTH; k++) begin
        lineI[k] <= '0;
        lineQ[k] <= '0;
      end
    end else if (strobe.shift) begin
      lineI[0] <= inI;
      lineQ[0] <= inQ;
      for (int k = 1; k < DEPTH; k++) begin
        lineI[k] <= lineI[k-1];
        lineQ[k] <= lineQ[k-1];
      end
    end
  end

  generate
    for (genvar g = 0; g < NUM_PATHS; g++) begin : gPath
      logic [TAP_W-1:0] tapSel;
      assign tapSel = tapFlat[g*TAP_W +: TAP_W];
      chanPathMul #(.DATA_W(DATA_W), .COEF_W(COEF_W)) uMul (
        .clk (clk),
        .rstN(rstN),
        .xI  (lineI[tapSel]),
        .xQ  (lineQ[tapSel]),
        .hI  (coefI[g*COEF_W +: COEF_W]),
        .hQ  (coefQ[g*COEF_W +: COEF_W]),
        .pI  (prodI[g]),
        .pQ  (prodQ[g])
      );
    end
  endgenerate

  always_comb begin
    accI = '0;
    accQ = '0;
    for (int p = 0; p < NUM_PATHS; p++) begin
      accI = accI + SUM_W'(prodI[p]);
      accQ = accQ + SUM_W'(prodQ[p]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sumI <= '0;
      sumQ <= '0;
    end else begin
      sumI <= accI;
      sumQ <= accQ;
    end
  end

  always_comb begin
    scaledI = (sumI + HALF) >>> FRAC;
    scaledQ = (sumQ + HALF) >>> FRAC;
    if (scaledI > MAX_V)      satI = MAX_V[DATA_W-1:0];
    else if (scaledI < MIN_V) satI = MIN_V[DATA_W-1:0];
    else                      satI = scaledI[DATA_W-1:0];
    if (scaledQ > MAX_V)      satQ = MAX_V[DATA_W-1:0];
    else if (scaledQ < MIN_V) satQ = MIN_V[DATA_W-1:0];
    else                      satQ = scaledQ[DATA_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outI <= '0;
      outQ <= '0;
    end else if (strobe.outLoad) begin
      outI <= satI;
      outQ <= satQ;
    end else begin
      outI <= '0;
      outQ <= '0;
    end
  end
endmodule

// File: rtl/chanTapFilter.sv
module chanTapFilter
  import chanPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter int NUM_PATHS = 12,
  parameter int DEPTH = 8,
  localparam int TAP_W = $clog2(DEPTH),
  localparam int PATH_W = $clog2(NUM_PATHS)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        enable,
  input  logic signed [DATA_W-1:0]    inI,
  input  logic signed [DATA_W-1:0]    inQ,
  input  logic [NUM_PATHS*COEF_W-1:0] coefI,
  input  logic [NUM_PATHS*COEF_W-1:0] coefQ,
  input  logic                        cfgWrEn,
  input  logic [PATH_W-1:0]           cfgPath,
  input  logic [TAP_W-1:0]            cfgTap,
  output logic signed [DATA_W-1:0]    outI,
  output logic signed [DATA_W-1:0]    outQ,
  output logic                        outValid
);
  logic [NUM_PATHS*TAP_W-1:0] tapFlat;
  ctlStrobe_t strobe;

  chanCtl #(.NUM_PATHS(NUM_PATHS), .DEPTH(DEPTH)) uCtl (
    .clk     (clk),
    .rstN    (rstN),
    .enable  (enable),
    .cfgWrEn (cfgWrEn),
    .cfgPath (cfgPath),
    .cfgTap  (cfgTap),
    .tapFlat (tapFlat),
    .strobe  (strobe),
    .outValid(outValid)
  );

  chanDatapath #(
    .DATA_W(DATA_W), .COEF_W(COEF_W), .NUM_PATHS(NUM_PATHS), .DEPTH(DEPTH)
  ) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .tapFlat(tapFlat),
    .inI    (inI),
    .inQ    (inQ),
    .coefI  (coefI),
    .coefQ  (coefQ),
    .outI   (outI),
    .outQ   (outQ)
  );
endmodule

// File: rtl/chanTapFilterChk.sv
module chanTapFilterChk #(
  parameter int DATA_W = 16,
  parameter int NUM_PATHS = 12,
  parameter int TAP_W = 3,
  parameter int PATH_W = 4
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       enable,
  input logic                       cfgWrEn,
  input logic [PATH_W-1:0]          cfgPath,
  input logic [TAP_W-1:0]           cfgTap,
  input logic [NUM_PATHS*TAP_W-1:0] tapFlat,
  input logic [DATA_W-1:0]          outI,
  input logic [DATA_W-1:0]          outQ,
  input logic                       outValid
);
  logic [2:0] sinceRst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceRst <= '0;
    else if (sinceRst != 3'd7) sinceRst <= sinceRst + 3'd1;
  end

  AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 3'd4) |-> (outValid == $past(enable, 4))); // R10

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> (outI == '0 && outQ == '0)); // R10

  AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (!enable && cfgWrEn && int'(cfgPath) < NUM_PATHS)
      |=> (tapFlat[$past(cfgPath)*TAP_W +: TAP_W] == $past(cfgTap))); // R8

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    enable |=> $stable(tapFlat)); // R9
endmodule

bind chanTapFilter chanTapFilterChk #(
  .DATA_W(DATA_W), .NUM_PATHS(NUM_PATHS), .TAP_W(TAP_W), .PATH_W(PATH_W)
) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .enable  (enable),
  .cfgWrEn (cfgWrEn),
  .cfgPath (cfgPath),
  .cfgTap  (cfgTap),
  .tapFlat (tapFlat),
  .outI    (outI),
  .outQ    (outQ),
  .outValid(outValid)
);

// File: tb/test_chanTapFilter.sv
`timescale 1ns/1ps
module test_chanTapFilter;
  localparam int DW = 16;
  localparam int CW = 16;
  localparam int NP = 12;
  localparam int DEPTH = 8;
  localparam int LAT = 3;
  localparam int MAXN = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic signed [DW-1:0] inI = '0, inQ = '0;
  logic [NP*CW-1:0] coefI = '0, coefQ = '0;
  logic cfgWrEn = 1'b0;
  logic [3:0] cfgPath = '0;
  logic [2:0] cfgTap = '0;
  logic signed [DW-1:0] outI, outQ;
  logic outValid;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  int xI [MAXN];
  int xQ [MAXN];
  int cI [MAXN][NP];
  int cQ [MAXN][NP];
  int benchTap [NP];

  always #5 clk = ~clk;

  chanTapFilter i_chanTapFilter (
    .clk(clk), .rstN(rstN), .enable(enable), .inI(inI), .inQ(inQ),
    .coefI(coefI), .coefQ(coefQ), .cfgWrEn(cfgWrEn), .cfgPath(cfgPath),
    .cfgTap(cfgTap), .outI(outI), .outQ(outQ), .outValid(outValid)
  );

  function automatic int sat16(longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  // Independent model: y[k] = sum_p c[k+1][p] * x[k - tap_p], Q1.15 rounding.
  function automatic void model(input int k, output int ei, output int eq);
    longint accI = 0;
    longint accQ = 0;
    for (int p = 0; p < NP; p++) begin
      int j = k - benchTap[p];
      if (j >= 0) begin
        longint a = xI[j];
        longint b = xQ[j];
        longint hi = cI[k+1][p];
        longint hq = cQ[k+1][p];
        accI += a * hi - b * hq;
        accQ += a * hq + b * hi;
      end
    end
    ei = sat16((accI + 16384) >>> 15);
    eq = sat16((accQ + 16384) >>> 15);
  endfunction

  task automatic clearVectors();
    for (int n = 0; n < MAXN; n++) begin
      xI[n] = 0;
      xQ[n] = 0;
      for (int p = 0; p < NP; p++) begin
        cI[n][p] = 0;
        cQ[n][p] = 0;
      end
    end
  endtask

  task automatic check(string tag, bit ok, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic setTap(int path, int tap);
    @(negedge clk);
    cfgWrEn = 1'b1;
    cfgPath = 4'(path);
    cfgTap = 3'(tap);
    @(negedge clk);
    cfgWrEn = 1'b0;
    benchTap[path] = tap;
  endtask

  // Drive len samples with enable high; optionally strobe a write at wrAt.
  task automatic runSeq(string tag, int len, int wrAt);
    for (int c = 0; c < len + LAT + 4; c++) begin
      @(negedge clk);
      if (c >= LAT + 1) begin
        int k = c - LAT - 1;
        if (k < len) begin
          int ei, eq;
          model(k, ei, eq);
          check(tag, outI == ei, $sformatf("outI[%0d]", k), outI, ei);
          check(tag, outQ == eq, $sformatf("outQ[%0d]", k), outQ, eq);
          check("R10", outValid == 1'b1, "outValid", outValid, 1);
        end else begin
          check("R10", outValid == 1'b0 && outI == 0 && outQ == 0,
                "idle output", outI, 0);
        end
      end
      enable = (c < len);
      inI = (c < len) ? DW'(xI[c]) : '0;
      inQ = (c < len) ? DW'(xQ[c]) : '0;
      for (int p = 0; p < NP; p++) begin
        coefI[p*CW +: CW] = (c < MAXN) ? CW'(cI[c][p]) : '0;
        coefQ[p*CW +: CW] = (c < MAXN) ? CW'(cQ[c][p]) : '0;
      end
      cfgWrEn = (c == wrAt);
      cfgPath = '0;
      cfgTap = 3'd5;
    end
    cfgWrEn = 1'b0;
  endtask

  task automatic setCoef(int p, int hi, int hq);
    for (int n = 0; n < MAXN; n++) begin
      cI[n][p] = hi;
      cQ[n][p] = hq;
    end
  endtask

  task automatic resetAllTaps();
    for (int p = 0; p < NP; p++) setTap(p, 0);
  endtask

  task automatic testReset();
    @(negedge clk);
    check("R1", outI == 0 && outQ == 0, "out after reset", outI, 0);
    check("R1", outValid == 1'b0, "outValid after reset", outValid, 0);
  endtask

  task automatic testRounding();
    clearVectors();
    setCoef(0, 16384, 0);
    xI[8] = 1000; xI[10] = 3; xI[12] = -3; xQ[14] = 5;
    runSeq("R2/R6", 24, -1);
  endtask

  task automatic testMultiTap();
    clearVectors();
    setTap(1, 3);
    setTap(2, 7);
    setCoef(0, 20000, -3000);
    setCoef(1, -9000, 12000);
    setCoef(2, 7000, 7000);
    xI[8] = 1000; xQ[8] = -500;
    xI[9] = -2000; xQ[9] = 1500;
    runSeq("R2/R4/R8", 26, -1);
  endtask

  task automatic testCollapse();
    clearVectors();
    resetAllTaps();
    setTap(1, 2);
    setTap(2, 2);
    setTap(3, 2);
    setCoef(1, 8000, 1000);
    setCoef(2, 6000, -2500);
    setCoef(3, -3000, 4000);
    xI[8] = 3000; xQ[8] = 1200;
    runSeq("R3", 20, -1);
  endtask

  task automatic testTimeVarying();
    clearVectors();
    resetAllTaps();
    setTap(0, 1);
    for (int n = 0; n < MAXN; n++) begin
      cI[n][0] = 1000 * n - 20000;
      cQ[n][0] = 500 * n - 9000;
    end
    for (int n = 8; n < 20; n++) begin
      xI[n] = 2000 + 100 * n;
      xQ[n] = -700;
    end
    runSeq("R5", 28, -1);
  endtask

  task automatic testSaturate();
    clearVectors();
    resetAllTaps();
    setCoef(0, 32767, 0);
    setCoef(1, 32767, 0);
    setCoef(2, 32767, 0);
    xI[8] = 32767; xI[10] = -32768;
    xQ[12] = 32767;
    runSeq("R7", 22, -1);
  endtask

  task automatic testCfgIgnored();
    clearVectors();
    resetAllTaps();
    setTap(0, 2);
    setCoef(0, 16384, 0);
    xI[8] = 4000; xI[16] = -4000;
    // write of tap 5 into path 0 strobed mid-run must be ignored (R9)
    runSeq("R9", 26, 6);
    clearVectors();
    setCoef(0, 16384, 0);
    xI[8] = 1234;
    runSeq("R9", 20, -1);
  endtask

  initial begin
    for (int p = 0; p < NP; p++) benchTap[p] = 0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testRounding();
    testMultiTap();
    testCollapse();
    testTimeVarying();
    testSaturate();
    testCfgIgnored();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule